// File: doc/BRIEF.md
# Unaligned Load/Store Byte-Merge Unit

This datapath block forms the result of a partial-word access. It is used as a pair of such accesses that together read or write one 32-bit word at an address that is not word aligned. For a load it takes the aligned memory word that holds the addressed byte, together with the current value of the destination register. It moves the selected bytes into one end of the register and keeps every other byte of the old value. For a store it does the reverse: it takes bytes from one end of the register and places them into the addressed byte lanes of the memory word. It also returns a byte-enable mask that marks the lanes it wrote.

A *left* access moves the part of the word that starts at the addressed byte. In big-endian mode that part reaches to the end of the aligned word. A *right* access moves the part that reaches back to the addressed byte from the other side. The little-endian mode reverses which bytes are taken and which are dropped. To build an unaligned word in big-endian mode, issue a left access at the word's first byte address and then a right access at its last. In little-endian mode the pair is a right access at the first byte address and then a left access at the last. Generating the memory access, aligning the address and writing the register file back are left to the surrounding pipeline.

Each request enters through a valid/ready port and each result leaves through another. With the default `REG_OUT=1`, one register stage sits between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the stage is empty or its result is being taken in the same cycle. A result held while `out_ready` is low stays unchanged until it is taken. With `REG_OUT=0` the unit is purely combinational, and the handshake passes straight through.

Top module: `umerge_unit`

## Requirements
- R1: Left load. The effective offset s equals the byte offset k in big-endian mode and 3-k in little-endian mode. Every register lane i >= s (lane 0 is bits 7:0) receives memory word lane i-s. Lanes below s keep the value of `in_reg`. `out_lanes` marks the replaced lanes.
- R2: Right load. Every register lane i <= s receives memory word lane i+3-s. Lanes above s keep the value of `in_reg`.
- R3: Byte ordering. `in_little`=0 selects big-endian mode, where the byte at offset a lies in word lane 3-a. `in_little`=1 selects little-endian mode, where that byte lies in word lane a. Each mode selects the byte set that this ordering implies.
- R4: Assembling an unaligned word. In big-endian mode, a left load at the first byte address followed by a right load at the last byte address produces the whole word, first byte most significant. In little-endian mode, a right load at the first byte address followed by a left load at the last byte address produces the whole word, first byte least significant.
- R5: Left store. Memory word lanes 0..3-s receive register lanes s..3 in order. The other memory lanes keep their `in_word` value.
- R6: Right store. Memory word lanes 3-s..3 receive register lanes 0..s in order. The other memory lanes keep their `in_word` value.
- R7: `out_lanes` has exactly the transferred lanes set. A left access sets 4-s lanes and a right access sets s+1 lanes. The set always includes lane 3 when a load is left or a store is right, and lane 0 otherwise.
- R8: In big-endian mode, a left load at k=0 and a right load at k=3 each replace the whole register with the memory word.
- R9: Handshake (REG_OUT=1). While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_lanes` hold their values. No accepted request is lost or duplicated.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit accepts a request this cycle |
| in_word | input | 32 | Aligned memory word |
| in_reg | input | 32 | Current destination/source register value |
| in_ofs | input | 2 | Low address bits (byte offset in the word) |
| in_left | input | 1 | 1 = left variant, 0 = right variant |
| in_store | input | 1 | 1 = partial store, 0 = partial load |
| in_little | input | 1 | 1 = little-endian mode, 0 = big-endian |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Merged register value (load) or modified memory word (store) |
| out_lanes | output | 4 | Byte lanes written in `out_data` |

## Verification
Assertions check on every cycle that the lane mask has the population count set by the offset and direction. They also check that the mask is anchored at the correct end, that an aligned big-endian load covers all four lanes, and that a stalled result stays frozen while the input is refused. Only the bench's scenarios show which byte value lands in which lane under each ordering, that untouched lanes keep their old content, and that two chained partial loads assemble a complete unaligned word. The bench sweeps every offset, direction, load/store choice and byte ordering over several data patterns. It compares each result with a byte-address model.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

  typedef struct packed {
    logic store;   // 1: partial store, 0: partial load
    logic left;    // 1: left variant
    logic little;  // 1: little-endian byte order
  } umerge_ctl_t;

endpackage

// File: rtl/umerge_lane_decode.sv
module umerge_lane_decode
  import umerge_pkg::*;
#(
  parameter int NB = 4,
  localparam int OW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [OW-1:0] ofs,
  input  umerge_ctl_t   ctl,
  output logic [OW-1:0] amt,
  output logic          dir_up,
  output logic [NB-1:0] lanes
);

  localparam logic [OW-1:0] TOP = OW'(NB - 1);

  logic [OW-1:0] eff;

  // effective offset: ordering folds onto one shift rule
  always_comb begin
    eff    = ctl.little ? (TOP - ofs) : ofs;
    amt    = ctl.left ? eff : (TOP - eff);
    dir_up = ctl.store ^ ctl.left;
  end

  generate
    for (genvar i = 0; i < NB; i++) begin : g_lane
      always_comb begin
        if (dir_up) lanes[i] = (OW'(i) >= amt);
        else        lanes[i] = (OW'(i) <= (TOP - amt));
      end
    end
  endgenerate

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ($countones(lanes) == (ctl.left ? (NB - int'(eff)) : (int'(eff) + 1)))); // R7

  AST_LANE_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ((ctl.left != ctl.store) ? lanes[NB-1] : lanes[0])); // R7

  AST_ALIGNED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !ctl.little && !ctl.store &&
     ((ctl.left && ofs == '0) || (!ctl.left && ofs == TOP))) |-> (&lanes)); // R8

endmodule

// File: rtl/umerge_shifter.sv
module umerge_shifter #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int OW = $clog2(NB),
  localparam int W  = NB * BW
) (
  input  logic [W-1:0]  src,
  input  logic [OW-1:0] amt,
  input  logic          up,
  output logic [W-1:0]  dst
);

  // lane i takes src lane i-amt (up) or i+amt (down)
  generate
    for (genvar i = 0; i < NB; i++) begin : g_lane
      always_comb begin
        dst[i*BW +: BW] = '0;
        for (int j = 0; j < NB; j++) begin
          if (up && (i - j) == int'(amt))
            dst[i*BW +: BW] = src[j*BW +: BW];
          else if (!up && (j - i) == int'(amt))
            dst[i*BW +: BW] = src[j*BW +: BW];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/umerge_lane_mux.sv
module umerge_lane_mux #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int W = NB * BW
) (
  input  logic [W-1:0]  moved,
  input  logic [W-1:0]  base,
  input  logic [NB-1:0] lanes,
  output logic [W-1:0]  merged
);

  generate
    for (genvar i = 0; i < NB; i++) begin : g_lane
      assign merged[i*BW +: BW] = lanes[i] ? moved[i*BW +: BW] : base[i*BW +: BW];
    end
  endgenerate

endmodule

// File: rtl/umerge_out_stage.sv
module umerge_out_stage #(
  parameter int W  = 36,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (up_ready) begin
          vld_q <= up_valid;
          if (up_valid) dat_q <= up_data;
        end
      end

      assign up_ready = !vld_q || dn_ready;
      assign dn_valid = vld_q;
      assign dn_data  = dat_q;

      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R9
    end else begin : g_comb
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate

  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready); // R9

endmodule

// File: rtl/umerge_unit.sv
module umerge_unit
  import umerge_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int OW = $clog2(NB),
  localparam int W  = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_word,
  input  logic [W-1:0]  in_reg,
  input  logic [OW-1:0] in_ofs,
  input  logic          in_left,
  input  logic          in_store,
  input  logic          in_little,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [NB-1:0] out_lanes
);

  umerge_ctl_t   ctl;
  logic [OW-1:0] amt;
  logic          up;
  logic [NB-1:0] lanes;
  logic [W-1:0]  src, base, moved, merged;

  assign ctl  = '{store: in_store, left: in_left, little: in_little};
  assign src  = in_store ? in_reg  : in_word;
  assign base = in_store ? in_word : in_reg;

  umerge_lane_decode #(.NB(NB)) u_dec (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
    .ofs(in_ofs), .ctl(ctl), .amt(amt), .dir_up(up), .lanes(lanes)
  );

  umerge_shifter #(.NB(NB), .BW(BW)) u_shf (
    .src(src), .amt(amt), .up(up), .dst(moved)
  );

  umerge_lane_mux #(.NB(NB), .BW(BW)) u_mux (
    .moved(moved), .base(base), .lanes(lanes), .merged(merged)
  );

  umerge_out_stage #(.W(W + NB), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data({lanes, merged}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data({out_lanes, out_data})
  );

endmodule

// File: tb/tb_umerge_unit.sv
module tb_umerge_unit;
  localparam int CLK_P = 10;
  localparam int MAXC  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_word = '0, in_reg = '0;
  logic [1:0]  in_ofs = '0;
  logic        in_left = 1'b0, in_store = 1'b0, in_little = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_lanes;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  umerge_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_reg(in_reg), .in_ofs(in_ofs), .in_left(in_left),
    .in_store(in_store), .in_little(in_little), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_lanes(out_lanes)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // byte-address model: returns {lanes, data}
  function automatic logic [35:0] model(input logic [31:0] w, input logic [31:0] r,
                                        input int k, input bit left, input bit st, input bit le);
    logic [31:0] d;
    logic [3:0]  ln;
    d  = st ? w : r;
    ln = '0;
    for (int j = 0; j < 4; j++) begin
      int a, rl, wl;
      bit use_it;
      if (left) begin
        use_it = le ? (j <= k) : (j <= 3 - k);
        a      = le ? k - j : k + j;
        rl     = 3 - j;
      end else begin
        use_it = le ? (j <= 3 - k) : (j <= k);
        a      = le ? k + j : k - j;
        rl     = j;
      end
      if (use_it) begin
        wl = le ? a : 3 - a;
        if (st) begin d[8*wl +: 8] = r[8*rl +: 8]; ln[wl] = 1'b1; end
        else    begin d[8*rl +: 8] = w[8*wl +: 8]; ln[rl] = 1'b1; end
      end
    end
    return {ln, d};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] r, input int k,
                       input bit left, input bit st, input bit le);
    @(negedge clk);
    in_word = w; in_reg = r; in_ofs = 2'(k);
    in_left = left; in_store = st; in_little = le;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] wpat [3];
    logic [31:0] rpat [3];
    logic [35:0] e;
    logic [31:0] acc;
    wpat[0] = 32'h11223344; rpat[0] = 32'hAABBCCDD;
    wpat[1] = 32'hF0E1D2C3; rpat[1] = 32'h0F1E2D3C;
    wpat[2] = 32'h00000000; rpat[2] = 32'hFFFFFFFF;

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset during rst", {34'h0, out_valid, in_ready}, 36'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 after reset", {34'h0, out_valid, in_ready}, 36'h1);

    // exhaustive sweep: R1 R2 R3 R5 R6 R7
    for (int p = 0; p < 3; p++)
      for (int le = 0; le < 2; le++)
        for (int st = 0; st < 2; st++)
          for (int lf = 0; lf < 2; lf++)
            for (int k = 0; k < 4; k++) begin
              string tag;
              issue(wpat[p], rpat[p], k, lf[0], st[0], le[0]);
              e = model(wpat[p], rpat[p], k, lf[0], st[0], le[0]);
              tag = st ? (lf ? "R5" : "R6") : (lf ? "R1" : "R2");
              tag = $sformatf("%s%s k=%0d", tag, le ? " R3 LE" : " BE", k);
              check(out_valid && out_data == e[31:0], {tag, " data"}, {out_lanes, out_data}, e);
              check(out_lanes == e[35:32], {"R7 lanes ", tag}, {32'h0, out_lanes}, {32'h0, e[35:32]});
            end

    // R8: aligned big-endian loads replace the whole register
    issue(32'hCAFEF00D, 32'h12345678, 0, 1'b1, 1'b0, 1'b0);
    check(out_data == 32'hCAFEF00D && out_lanes == 4'hF, "R8 left k=0", {out_lanes, out_data}, {4'hF, 32'hCAFEF00D});
    issue(32'hCAFEF00D, 32'h12345678, 3, 1'b0, 1'b0, 1'b0);
    check(out_data == 32'hCAFEF00D && out_lanes == 4'hF, "R8 right k=3", {out_lanes, out_data}, {4'hF, 32'hCAFEF00D});

    // R4 big-endian: bytes at addresses 1..4, addr n holds A0+n
    issue(32'hA0A1A2A3, 32'h0, 1, 1'b1, 1'b0, 1'b0);
    acc = out_data;
    issue(32'hA4A5A6A7, acc, 0, 1'b0, 1'b0, 1'b0);
    check(out_data == 32'hA1A2A3A4, "R4 BE pair", {4'h0, out_data}, {4'h0, 32'hA1A2A3A4});
    // R4 little-endian: right at first byte, left at last
    issue(32'hA3A2A1A0, 32'h0, 1, 1'b0, 1'b0, 1'b1);
    acc = out_data;
    issue(32'hA7A6A5A4, acc, 0, 1'b1, 1'b0, 1'b1);
    check(out_data == 32'hA4A3A2A1, "R4 LE pair", {4'h0, out_data}, {4'h0, 32'hA4A3A2A1});

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_word = 32'h01020304; in_reg = 32'h0; in_ofs = 2'd0;
    in_left = 1'b1; in_store = 1'b0; in_little = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_data == 32'h01020304, "R9 first held", {4'h0, out_data}, {4'h0, 32'h01020304});
    in_word = 32'h05060708;
    check(in_ready == 1'b0, "R9 in_ready low on stall", {35'h0, in_ready}, 36'h0);
    @(negedge clk);
    check(out_valid && out_data == 32'h01020304, "R9 stable while stalled", {4'h0, out_data}, {4'h0, 32'h01020304});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 32'h05060708, "R9 second after release", {4'h0, out_data}, {4'h0, 32'h05060708});
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drained, no duplicate", {35'h0, out_valid}, 36'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (MAXC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", MAXC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule